// File: doc/BRIEF.md
# Physical Memory Protection Checker with Effective Privilege

This block decides whether a physical memory access made by a hart may proceed. Each request carries an address, an access kind (load, store or instruction fetch), the hart's current privilege, the two machine-status fields that let machine-mode code make its data accesses under a lower privilege (a "modify privilege" enable and a "previous privilege" field), and the success flag of the address translation that came before. The checker first works out the privilege that the memory access really runs under. It then searches a small table of protection entries and reports allow or deny, a violation flag and the index of the entry that decided the result.

Software loads the table through a narrow write port. Each entry has a configuration byte and an address word. The configuration byte holds the read, write and execute rights, an address-matching mode and a lock bit. A locked entry binds machine mode as well as lower modes, and it cannot be rewritten until reset. Results are registered. They appear one cycle after a request strobe and then hold until the next request.

Top module: `pmp_checker`

## Requirements
- R1: When the current privilege is M (code 3), the access is not a fetch and the modify-privilege enable is set, the privilege used for the check is the previous-privilege field (U=0, S=1, M=3). Otherwise the check uses the current privilege.
- R2: An instruction fetch (access code 2) always uses the current privilege, whatever the modify-privilege enable holds.
- R3: When an entry matches, the effective privilege is M and the entry's lock bit (configuration bit 7) is clear, reads, writes and fetches are all allowed.
- R4: When an entry matches and either the effective privilege is below M or the entry is locked, the access is allowed only if the entry grants its right. The right needed is bit (access code) of the configuration: read bit 0 for load (0), write bit 1 for store (1), execute bit 2 for fetch (2).
- R5: When no entry matches, an access with effective privilege M is allowed and any other access is denied with the violation flag set.
- R6: Entries are searched from index 0 upward. The lowest-indexed matching entry alone decides the result, and its index is reported with the hit flag.
- R7: Matching mode 1 (configuration bits 4:3) is top-of-range. It matches word addresses (address bits 31:2) from the previous entry's address word, inclusive, up to its own address word, exclusive. Entry 0 uses zero as its lower bound.
- R8: Matching mode 3 is a naturally aligned power-of-two region. With k trailing ones in the address word, it covers 2^(k+3) bytes aligned to that size.
- R9: Matching mode 0 (and the unused mode 2) never matches.
- R10: Writes to the configuration or address word of a locked entry are ignored until reset.
- R11: When the translation flag is low, the result is deny with the violation flag, hit flag and index all zero.
- R12: A request strobe produces a valid response on the next cycle. In cycles without a strobe the valid flag is low and the result fields keep their previous values.
- R13: After reset the response fields are zero and every entry is unlocked with matching turned off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_cfg | input | 1 | 1 writes the configuration byte, 0 writes the address word |
| wr_idx | input | 2 | Entry selected for the write |
| wr_data | input | 30 | Write data; bits 7:0 used for configuration |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Physical byte address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_priv | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| req_mprv | input | 1 | Modify-privilege enable from machine status |
| req_mpp | input | 2 | Previous-privilege field from machine status |
| req_xlat_ok | input | 1 | Translation before this check succeeded |
| rsp_valid | output | 1 | Response valid, one cycle after req_valid |
| rsp_allow | output | 1 | Access permitted |
| rsp_violation | output | 1 | Protection check refused the access |
| rsp_hit | output | 1 | An entry matched |
| rsp_idx | output | 2 | Index of the deciding entry |

## Verification
A directed table builds overlapping regions. A read-only top-of-range entry at index 0 sits inside a wider read-write region at index 1, so a user store tells first-match priority apart from any-match. A locked execute-only region sits beside a top-of-range entry whose lower bound is that locked entry's address word. Probes at the exact range edges check the inclusive and exclusive bounds. Machine-mode probes with the modify-privilege enable set, on data and on fetches, separate the effective privilege from the current one. Addresses that match no entry separate the machine-mode default from the lower-mode default. Random requests and random table rewrites are then compared against a bench model, with occasional failed translations, rewrites of locked entries and idle cycles.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [1:0] AM_OFF   = 2'd0;
  localparam logic [1:0] AM_TOR   = 2'd1;
  localparam logic [1:0] AM_NAPOT = 2'd3;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    logic [1:0] amode;
    logic       x;
    logic       w;
    logic       r;
  } pmp_cfg_t;

endpackage

// File: rtl/pmp_eff_priv.sv
module pmp_eff_priv
  import pmp_pkg::*;
(
  input  logic [1:0] cur_priv,
  input  logic [1:0] kind,
  input  logic       mprv,
  input  logic [1:0] mpp,
  output logic [1:0] eff_priv
);

  logic data_access;

  always_comb begin
    data_access = (kind != KIND_FETCH);
    eff_priv    = cur_priv;
    if ((cur_priv == PRIV_M) && data_access && mprv) begin
      eff_priv = mpp;
    end
  end

endmodule

// File: rtl/pmp_regs.sv
module pmp_regs
  import pmp_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int WORD_W = 30,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         wr_cfg,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [WORD_W-1:0]            wr_data,
  output pmp_cfg_t [N_ENT-1:0]         cfg_o,
  output logic [N_ENT-1:0][WORD_W-1:0] addr_o
);

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    pmp_cfg_t          cfg_q, cfg_d;
    logic [WORD_W-1:0] addr_q, addr_d;
    logic              sel;

    always_comb begin
      sel    = wr_en && (wr_idx == IDX_W'(i)) && !cfg_q.lock;
      cfg_d  = cfg_q;
      addr_d = addr_q;
      if (sel && wr_cfg) begin
        cfg_d = pmp_cfg_t'(wr_data[7:0]);
      end
      if (sel && !wr_cfg) begin
        addr_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q  <= '0;
        addr_q <= '0;
      end else if (sel) begin
        cfg_q  <= cfg_d;
        addr_q <= addr_d;
      end
    end

    assign cfg_o[i]  = cfg_q;
    assign addr_o[i] = addr_q;

    // R10: a locked entry keeps both registers until reset
    p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.lock |=> ($stable(cfg_q) && $stable(addr_q)));
  end

endmodule

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
  import pmp_pkg::*;
#(
  parameter int WORD_W = 30
) (
  input  logic [WORD_W-1:0] word_addr,
  input  logic [1:0]        amode,
  input  logic [WORD_W-1:0] lo_bound,
  input  logic [WORD_W-1:0] ent_addr,
  output logic              hit
);

  logic [WORD_W-1:0] care_n;
  logic              tor_hit, napot_hit;

  always_comb begin
    care_n    = ent_addr ^ (ent_addr + WORD_W'(1));
    tor_hit   = (word_addr >= lo_bound) && (word_addr < ent_addr);
    napot_hit = (((word_addr ^ ent_addr) & ~care_n) == '0);
    case (amode)
      AM_TOR:   hit = tor_hit;
      AM_NAPOT: hit = napot_hit;
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmp_resolve.sv
module pmp_resolve
  import pmp_pkg::*;
#(
  parameter int N_ENT  = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [N_ENT-1:0]     hits,
  input  pmp_cfg_t [N_ENT-1:0] cfg,
  input  logic [1:0]           eff_priv,
  output logic                 any_hit,
  output logic [IDX_W-1:0]     win_idx,
  output logic [2:0]           rights
);

  pmp_cfg_t win_cfg;
  logic     unused_cfg;

  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int k = N_ENT - 1; k >= 0; k--) begin
      if (hits[k]) begin
        any_hit = 1'b1;
        win_idx = IDX_W'(k);
      end
    end
    win_cfg = cfg[win_idx];
    if (any_hit) begin
      if ((eff_priv == PRIV_M) && !win_cfg.lock) rights = 3'b111;
      else rights = {win_cfg.x, win_cfg.w, win_cfg.r};
    end else begin
      rights = (eff_priv == PRIV_M) ? 3'b111 : 3'b000;
    end
  end

  assign unused_cfg = ^{win_cfg.rsvd, win_cfg.amode};

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int PA_W   = 32,
  localparam int WORD_W = PA_W - 2,
  localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_cfg,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              req_valid,
  input  logic [PA_W-1:0]   req_addr,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_priv,
  input  logic              req_mprv,
  input  logic [1:0]        req_mpp,
  input  logic              req_xlat_ok,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic              rsp_violation,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_idx
);

  pmp_cfg_t [N_ENT-1:0]         cfg;
  logic [N_ENT-1:0][WORD_W-1:0] ent_addr;
  logic [N_ENT-1:0][WORD_W-1:0] lo_bound;
  logic [N_ENT-1:0]             hits;
  logic [WORD_W-1:0]            word_addr;
  logic [1:0]                   eff_priv;
  logic                         any_hit;
  logic [IDX_W-1:0]             win_idx;
  logic [2:0]                   rights;
  logic [3:0]                   need;
  logic                         pmp_ok;
  logic                         unused_lo;

  logic             valid_q, valid_d;
  logic             allow_q, allow_d;
  logic             viol_q, viol_d;
  logic             hit_q, hit_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign word_addr = req_addr[PA_W-1:2];
  assign unused_lo = ^req_addr[1:0];

  pmp_regs #(.N_ENT(N_ENT), .WORD_W(WORD_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_cfg  (wr_cfg),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .cfg_o   (cfg),
    .addr_o  (ent_addr)
  );

  pmp_eff_priv u_eff (
    .cur_priv (req_priv),
    .kind     (req_kind),
    .mprv     (req_mprv),
    .mpp      (req_mpp),
    .eff_priv (eff_priv)
  );

  for (genvar i = 0; i < N_ENT; i++) begin : g_match
    if (i == 0) begin : g_first
      assign lo_bound[i] = '0;
    end else begin : g_rest
      assign lo_bound[i] = ent_addr[i-1];
    end

    pmp_entry_match #(.WORD_W(WORD_W)) u_match (
      .word_addr (word_addr),
      .amode     (cfg[i].amode),
      .lo_bound  (lo_bound[i]),
      .ent_addr  (ent_addr[i]),
      .hit       (hits[i])
    );
  end

  pmp_resolve #(.N_ENT(N_ENT)) u_resolve (
    .hits     (hits),
    .cfg      (cfg),
    .eff_priv (eff_priv),
    .any_hit  (any_hit),
    .win_idx  (win_idx),
    .rights   (rights)
  );

  always_comb begin
    need    = 4'b0001 << req_kind;
    pmp_ok  = ((need & ~{1'b0, rights}) == 4'b0000);
    valid_d = req_valid;
    allow_d = allow_q;
    viol_d  = viol_q;
    hit_d   = hit_q;
    idx_d   = idx_q;
    if (req_valid) begin
      allow_d = req_xlat_ok && pmp_ok;
      viol_d  = req_xlat_ok && !pmp_ok;
      hit_d   = req_xlat_ok && any_hit;
      idx_d   = (req_xlat_ok && any_hit) ? win_idx : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allow_q <= 1'b0;
      viol_q  <= 1'b0;
      hit_q   <= 1'b0;
      idx_q   <= '0;
    end else if (req_valid) begin
      allow_q <= allow_d;
      viol_q  <= viol_d;
      hit_q   <= hit_d;
      idx_q   <= idx_d;
    end
  end

  assign rsp_valid     = valid_q;
  assign rsp_allow     = allow_q;
  assign rsp_violation = viol_q;
  assign rsp_hit       = hit_q;
  assign rsp_idx       = idx_q;

  p_resp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_allow) && $stable(rsp_violation)
                    && $stable(rsp_idx)));

  p_xlat_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_xlat_ok) |=> (!rsp_allow && !rsp_violation && !rsp_hit));

  p_nomatch_m_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_xlat_ok && !any_hit && (eff_priv == PRIV_M)) |=> rsp_allow);

  p_nomatch_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_xlat_ok && (hits == '0) && (eff_priv != PRIV_M))
      |=> (!rsp_allow && rsp_violation));

  // R1: machine mode borrowing user privilege for a data access on an empty match
  p_mprv_user_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_xlat_ok && (req_priv == PRIV_M) && req_mprv
     && (req_kind != KIND_FETCH) && (req_mpp == PRIV_U) && (hits == '0))
      |=> !rsp_allow);

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_allow && rsp_violation));

endmodule

// File: tb/tb_pmp_checker.sv
module tb_pmp_checker;

  localparam int N = 4;

  logic        clk, rst_n;
  logic        wr_en, wr_cfg;
  logic [1:0]  wr_idx;
  logic [29:0] wr_data;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [1:0]  req_kind, req_priv, req_mpp;
  logic        req_mprv, req_xlat_ok;
  logic        rsp_valid, rsp_allow, rsp_violation, rsp_hit;
  logic [1:0]  rsp_idx;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [7:0]  m_cfg  [N];
  logic [29:0] m_addr [N];

  pmp_checker dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cfg(wr_cfg), .wr_idx(wr_idx),
    .wr_data(wr_data), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_priv(req_priv), .req_mprv(req_mprv),
    .req_mpp(req_mpp), .req_xlat_ok(req_xlat_ok), .rsp_valid(rsp_valid),
    .rsp_allow(rsp_allow), .rsp_violation(rsp_violation), .rsp_hit(rsp_hit),
    .rsp_idx(rsp_idx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] eff_of(logic [1:0] pr, logic [1:0] kd, logic mp, logic [1:0] pp);
    if (pr == 2'd3 && kd != 2'd2 && mp) return pp;
    return pr;
  endfunction

  function automatic logic entry_hit(int i, logic [29:0] w);
    logic [29:0] lo, top, m;
    lo  = (i == 0) ? 30'd0 : m_addr[i-1];
    top = m_addr[i];
    case (m_cfg[i][4:3])
      2'd1: return (w >= lo) && (w < top);
      2'd3: begin
        m = top ^ (top + 30'd1);
        return ((w ^ top) & ~m) == 30'd0;
      end
      default: return 1'b0;
    endcase
  endfunction

  // returns {hit, idx[1:0], allow, violation}
  function automatic logic [4:0] expect_of(logic [31:0] a, logic [1:0] kd, logic [1:0] pr,
                                           logic mp, logic [1:0] pp, logic xl);
    logic [1:0] e;
    logic [2:0] rts;
    logic ok;
    int win;
    if (!xl) return 5'b0;
    e = eff_of(pr, kd, mp, pp);
    win = -1;
    for (int i = N - 1; i >= 0; i--) if (entry_hit(i, a[31:2])) win = i;
    if (win < 0) rts = (e == 2'd3) ? 3'b111 : 3'b000;
    else if (e == 2'd3 && !m_cfg[win][7]) rts = 3'b111;
    else rts = m_cfg[win][2:0];
    ok = rts[kd];
    return {win >= 0, (win >= 0) ? 2'(win) : 2'd0, ok, !ok};
  endfunction

  task automatic write_reg(input logic is_cfg, input int idx, input logic [29:0] d);
    wr_en = 1'b1; wr_cfg = is_cfg; wr_idx = 2'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!m_cfg[idx][7]) begin
      if (is_cfg) m_cfg[idx] = d[7:0];
      else m_addr[idx] = d;
    end
  endtask

  task automatic do_req(input string tag, input logic [31:0] a, input logic [1:0] kd,
                        input logic [1:0] pr, input logic mp, input logic [1:0] pp,
                        input logic xl);
    logic [4:0] ex;
    ex = expect_of(a, kd, pr, mp, pp, xl);
    req_valid = 1'b1; req_addr = a; req_kind = kd; req_priv = pr;
    req_mprv = mp; req_mpp = pp; req_xlat_ok = xl;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " allow/violation"}, {30'd0, rsp_allow, rsp_violation}, {30'd0, ex[1:0]});
    check({tag, " hit/idx"}, {29'd0, rsp_hit, rsp_idx}, {29'd0, ex[4:2]});
  endtask

  function automatic logic [1:0] rnd_priv();
    case ($urandom % 3)
      0: return 2'd0;
      1: return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  initial begin
    logic a0, v0;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin m_cfg[i] = 8'd0; m_addr[i] = 30'd0; end
    rst_n = 1'b0; wr_en = 1'b0; wr_cfg = 1'b0; wr_idx = 2'd0; wr_data = 30'd0;
    req_valid = 1'b0; req_addr = 32'd0; req_kind = 2'd0; req_priv = 2'd0;
    req_mprv = 1'b0; req_mpp = 2'd0; req_xlat_ok = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13: reset state of the response
    check("R13 reset response", {27'd0, rsp_valid, rsp_allow, rsp_violation, rsp_hit, rsp_idx}, 32'd0);
    // R13/R9: empty table, user load misses
    do_req("R13 empty table user", 32'h80, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1);

    // table: 0 TOR [0,0x100) R ; 1 NAPOT 0..0x1FF RW ; 2 NAPOT 0x2000 32B X locked ; 3 TOR RW
    write_reg(1'b0, 0, 30'h40);
    write_reg(1'b1, 0, 30'h09);
    write_reg(1'b0, 1, 30'h3F);
    write_reg(1'b1, 1, 30'h1B);
    write_reg(1'b0, 2, 30'h803);
    write_reg(1'b1, 2, 30'h9C);
    write_reg(1'b0, 3, 30'h900);
    write_reg(1'b1, 3, 30'h0B);

    do_req("R4 user load in read-only TOR", 32'h80, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1);
    do_req("R6 user store lowest entry wins", 32'h80, 2'd1, 2'd0, 1'b0, 2'd0, 1'b1);
    do_req("R7 TOR top exclusive falls to NAPOT", 32'h100, 2'd1, 2'd0, 1'b0, 2'd0, 1'b1);
    do_req("R7 TOR last word inside", 32'hFC, 2'd1, 2'd1, 1'b0, 2'd0, 1'b1);
    do_req("R8 NAPOT upper edge", 32'h1FC, 2'd1, 2'd0, 1'b0, 2'd0, 1'b1);
    do_req("R8 NAPOT beyond edge", 32'h200, 2'd0, 2'd1, 1'b0, 2'd0, 1'b1);
    do_req("R3 machine store unlocked", 32'h80, 2'd1, 2'd3, 1'b0, 2'd0, 1'b1);
    do_req("R1 machine data under user via mprv", 32'h80, 2'd1, 2'd3, 1'b1, 2'd0, 1'b1);
    do_req("R1 machine data under supervisor miss", 32'h5000, 2'd0, 2'd3, 1'b1, 2'd1, 1'b1);
    do_req("R1 mprv with mpp machine", 32'h5000, 2'd0, 2'd3, 1'b1, 2'd3, 1'b1);
    do_req("R2 fetch ignores mprv", 32'h80, 2'd2, 2'd3, 1'b1, 2'd0, 1'b1);
    do_req("R2 user fetch no execute", 32'h80, 2'd2, 2'd0, 1'b0, 2'd0, 1'b1);
    do_req("R5 machine no match", 32'h5000, 2'd1, 2'd3, 1'b0, 2'd0, 1'b1);
    do_req("R5 supervisor no match", 32'h5000, 2'd0, 2'd1, 1'b0, 2'd0, 1'b1);
    do_req("R4 locked binds machine store", 32'h2000, 2'd1, 2'd3, 1'b0, 2'd0, 1'b1);
    do_req("R4 locked machine fetch", 32'h201C, 2'd2, 2'd3, 1'b0, 2'd0, 1'b1);
    do_req("R7 TOR lower bound from previous entry", 32'h2020, 2'd1, 2'd0, 1'b0, 2'd0, 1'b1);
    do_req("R7 TOR top edge", 32'h23FC, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1);
    do_req("R7 TOR past top", 32'h2400, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1);

    // R10: rewrite of the locked entry is dropped
    write_reg(1'b1, 2, 30'h1F);
    write_reg(1'b0, 2, 30'h0);
    do_req("R10 locked cfg unchanged", 32'h2000, 2'd1, 2'd3, 1'b0, 2'd0, 1'b1);
    do_req("R10 locked addr unchanged", 32'h2010, 2'd2, 2'd0, 1'b0, 2'd0, 1'b1);

    do_req("R11 translation failure", 32'h80, 2'd0, 2'd3, 1'b0, 2'd0, 1'b0);

    // R12: idle cycle holds the fields
    do_req("R12 before idle", 32'h80, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1);
    a0 = rsp_allow; v0 = rsp_violation;
    @(negedge clk);
    check("R12 idle valid low", 32'(rsp_valid), 32'd0);
    check("R12 idle hold", {30'd0, rsp_allow, rsp_violation}, {30'd0, a0, v0});

    // R9: turning entry 3 off
    write_reg(1'b1, 3, 30'h03);
    do_req("R9 off entry never matches", 32'h2020, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1);
    write_reg(1'b1, 3, 30'h13);
    do_req("R9 reserved mode never matches", 32'h2020, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1);

    // random mix against the model (R1-R11)
    for (int it = 0; it < 600; it++) begin
      if ($urandom % 10 == 0) begin
        logic [7:0] c;
        int idx;
        idx = int'($urandom % N);
        c = 8'($urandom) & 8'h1F;
        if ($urandom % 20 == 0) c[7] = 1'b1;
        if ($urandom % 2 == 0) write_reg(1'b1, idx, {22'd0, c});
        else write_reg(1'b0, idx, 30'($urandom % 32'hC00));
      end
      if ($urandom % 8 == 0) @(negedge clk);
      do_req("R6 random", 32'($urandom % 32'h3000) & 32'hFFFF_FFFC, 2'($urandom % 3),
             rnd_priv(), 1'($urandom), rnd_priv(), ($urandom % 10) != 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule